// File: doc/BRIEF.md
# Byte-Wide USB FIFO Bridge Controller

This block connects on-chip user logic to an external USB FIFO chip that exchanges bytes over one shared 8-bit bus. The user side has two streams, each with a valid/ready handshake. The transmit stream carries bytes toward the host, and the receive stream delivers bytes that arrive from the host. On the device side the block drives an active-low read strobe and an active-high write strobe. It also watches two active-low flags: one says the device has room to take a byte, the other says a byte is waiting to be read.

The device raises its flag after every byte that is moved. For that reason the controller arms each direction again only after it has seen the flag high and then low once more. Both flags are asynchronous, so each one is resynchronized through two flops before any decision uses it. The bus is split into an input, an output and an output enable, and the enable is asserted only inside a write cycle. A gap state after every transfer keeps a read and a write from ever driving the bus together.

Strobe widths and the data lead time before the write strobe are parameters counted in system clocks. When both directions are pending, the read wins as long as the one-byte receive holding register is empty. A transmit byte is taken from the user only in the cycle the controller commits it to a write.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While reset is asserted, usbRdN is 1, usbWr is 0, usbDataOe is 0, txReady is 0 and rxValid is 0.
- R2: Each write cycle drives usbDataOe high for at least WR_SETUP (default 4) cycles before usbWr rises. It then holds usbWr high for exactly WR_PULSE (default 4) cycles and keeps usbDataOe high in the cycle usbWr falls. Throughout, usbDataOut carries the accepted bytes in the order they were accepted.
- R3: A write starts only while usbTxeN is low, and at most one write occurs per low episode of usbTxeN. A further write waits until the flag has been seen high and then low again.
- R4: A read holds usbRdN low for exactly RD_PULSE (default 4) cycles. The byte present on usbDataIn in the last low cycle is presented on rxData with rxValid high, and bytes arrive in order.
- R5: A read starts only while usbRxfN is low, and at most one read occurs per low episode of usbRxfN.
- R6: While rxValid is high and rxReady is low, rxValid and rxData stay unchanged. No read starts while rxValid is high.
- R7: When both flags become usable in the same cycle, the transmit byte is valid and the receive register is empty, the read is started first.
- R8: While the receive register stays full, pending writes still proceed.
- R9: usbDataOe is low whenever usbRdN is low and in the cycle right after usbRdN was low.
- R10: txReady is high only together with txValid, and only in a cycle that commits a write. The number of accepted bytes equals the number of writes started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 8 | Byte to send toward the host |
| txValid | input | 1 | txData holds a byte to send |
| txReady | output | 1 | Byte accepted this cycle (write committed) |
| rxData | output | 8 | Byte received from the host |
| rxValid | output | 1 | rxData holds a byte |
| rxReady | input | 1 | User takes rxData this cycle |
| usbDataIn | input | 8 | Bus value sampled from the pins |
| usbDataOut | output | 8 | Bus value driven to the pins |
| usbDataOe | output | 1 | Output enable for the bus drivers |
| usbRdN | output | 1 | Active-low read strobe to the device |
| usbWr | output | 1 | Write strobe to the device |
| usbTxeN | input | 1 | Active-low: device can take a byte (asynchronous) |
| usbRxfN | input | 1 | Active-low: device holds a byte to read (asynchronous) |

## Verification
The device model in the bench raises each flag after every transfer and lowers it again after a random delay, which sometimes includes a long busy stretch on the transmit side. The user side applies random valid and ready gaps, so the bench can tell correct re-arming from a second transfer within one flag episode. A directed start releases both flags in the same cycle, which separates the read-first priority from a write-first one. A long stall of the receive consumer keeps the holding register full, which shows whether writes go on while reads are held back. Byte streams built from distinct index formulas in each direction expose lost, duplicated or swapped bytes, and a capture taken at the wrong moment of the read strobe.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic loadTx;    // latch user byte into the bus output register
    logic driveBus;  // enable bus drivers
    logic capRx;     // capture bus into receive register
  } ufbStrobe_t;
endpackage

// File: rtl/ufb_sync.sv
module ufb_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) pipe[0] <= {W{RST_VAL}};
    else       pipe[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) pipe[s] <= {W{RST_VAL}};
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/ufb_ctrl.sv
module ufb_ctrl
  import ufb_pkg::*;
#(
  parameter int RD_PULSE = 4,
  parameter int WR_PULSE = 4,
  parameter int WR_SETUP = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txeLow,
  input  logic       rxfLow,
  input  logic       txValid,
  input  logic       rxFull,
  output logic       txReady,
  output logic       usbRdN,
  output logic       usbWr,
  output ufbStrobe_t strb
);
  localparam int MAX_AB = (RD_PULSE > WR_PULSE) ? RD_PULSE : WR_PULSE;
  localparam int MAX_C  = (MAX_AB > WR_SETUP) ? MAX_AB : WR_SETUP;
  localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WSET, ST_WPUL, ST_WHOLD, ST_GAP
  } state_t;

  state_t        state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic          txArm, rxArm;
  logic          rdGo, wrGo, commitWr, lastRd;

  assign rdGo     = rxArm && rxfLow && !rxFull;
  assign wrGo     = txArm && txeLow && txValid;
  assign commitWr = (state == ST_IDLE) && !rdGo && wrGo;
  assign lastRd   = (state == ST_RD) && (cnt == '0);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (rdGo) begin
          stateNxt = ST_RD;
          cntNxt   = CW'(RD_PULSE - 1);
        end else if (wrGo) begin
          stateNxt = ST_WSET;
          cntNxt   = CW'(WR_SETUP - 1);
        end
      end
      ST_RD: begin
        if (cnt == '0) stateNxt = ST_GAP;
        else           cntNxt   = cnt - 1'b1;
      end
      ST_WSET: begin
        if (cnt == '0) begin
          stateNxt = ST_WPUL;
          cntNxt   = CW'(WR_PULSE - 1);
        end else cntNxt = cnt - 1'b1;
      end
      ST_WPUL: begin
        if (cnt == '0) stateNxt = ST_WHOLD;
        else           cntNxt   = cnt - 1'b1;
      end
      ST_WHOLD: stateNxt = ST_GAP;
      ST_GAP:   stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      txArm <= 1'b1;
      rxArm <= 1'b1;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (commitWr)     txArm <= 1'b0;
      else if (!txeLow) txArm <= 1'b1;
      if ((state == ST_IDLE) && rdGo) rxArm <= 1'b0;
      else if (!rxfLow)               rxArm <= 1'b1;
    end
  end

  assign txReady       = commitWr;
  assign usbRdN        = (state != ST_RD);
  assign usbWr         = (state == ST_WPUL);
  assign strb.loadTx   = commitWr;
  assign strb.driveBus = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WHOLD);
  assign strb.capRx    = lastRd;

  AST_TXREADY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txValid);  // R10
  AST_WR_AFTER_FLAG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |-> txeLow);  // R3
  AST_RD_AFTER_FLAG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(usbRdN) |-> $past(rxfLow));  // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(usbWr && !usbRdN));  // R9
endmodule

// File: rtl/ufb_datapath.sv
module ufb_datapath
  import ufb_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ufbStrobe_t   strb,
  input  logic [W-1:0] txData,
  output logic [W-1:0] rxData,
  output logic         rxValid,
  input  logic         rxReady,
  input  logic [W-1:0] usbDataIn,
  output logic [W-1:0] usbDataOut,
  output logic         usbDataOe,
  output logic         rxFull
);
  logic [W-1:0] txHold, rxHold;
  logic         rxHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
      rxHold <= '0;
      rxHeld <= 1'b0;
    end else begin
      if (strb.loadTx) txHold <= txData;
      if (strb.capRx) begin
        rxHold <= usbDataIn;
        rxHeld <= 1'b1;
      end else if (rxHeld && rxReady) begin
        rxHeld <= 1'b0;
      end
    end
  end

  assign usbDataOut = txHold;
  assign usbDataOe  = strb.driveBus;
  assign rxData     = rxHold;
  assign rxValid    = rxHeld;
  assign rxFull     = rxHeld;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid && $stable(rxData));  // R6
  AST_TX_STABLE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    usbDataOe && $past(usbDataOe) |-> $stable(usbDataOut));  // R2
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge
  import ufb_pkg::*;
#(
  parameter int RD_PULSE   = 4,
  parameter int WR_PULSE   = 4,
  parameter int WR_SETUP   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  input  logic [7:0] usbDataIn,
  output logic [7:0] usbDataOut,
  output logic       usbDataOe,
  output logic       usbRdN,
  output logic       usbWr,
  input  logic       usbTxeN,
  input  logic       usbRxfN
);
  logic [1:0] flagSync;
  logic       rxFull;
  ufbStrobe_t strb;

  ufb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({usbTxeN, usbRxfN}),
    .syncOut(flagSync)
  );

  ufb_ctrl #(.RD_PULSE(RD_PULSE), .WR_PULSE(WR_PULSE), .WR_SETUP(WR_SETUP)) uCtrl (
    .clk(clk), .rstN(rstN),
    .txeLow(!flagSync[1]), .rxfLow(!flagSync[0]),
    .txValid(txValid), .rxFull(rxFull),
    .txReady(txReady), .usbRdN(usbRdN), .usbWr(usbWr),
    .strb(strb)
  );

  ufb_datapath #(.W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txData(txData), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .usbDataIn(usbDataIn), .usbDataOut(usbDataOut), .usbDataOe(usbDataOe),
    .rxFull(rxFull)
  );

  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    !usbRdN |-> !usbDataOe);  // R9
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $past(!usbRdN) |-> !usbDataOe);  // R9
  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    usbWr |-> usbDataOe);  // R2
  AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(usbRdN) |-> !rxValid);  // R6
endmodule

// File: tb/tb_usb_fifo_bridge.sv
module tb_usb_fifo_bridge;
  localparam int RD_PULSE = 4;
  localparam int WR_PULSE = 4;
  localparam int WR_SETUP = 4;
  localparam int NTX = 60;
  localparam int NRX = 60;
  localparam int WATCHDOG = 50000;
  localparam int STALL_LO = 400;
  localparam int STALL_HI = 700;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] txData = '0;
  logic txValid = 1'b0;
  logic txReady;
  logic [7:0] rxData;
  logic rxValid;
  logic rxReady = 1'b0;
  logic [7:0] usbDataIn = 8'h5A;
  logic [7:0] usbDataOut;
  logic usbDataOe, usbRdN, usbWr;
  logic usbTxeN = 1'b1;
  logic usbRxfN = 1'b1;

  always #5 clk = ~clk;

  usb_fifo_bridge #(.RD_PULSE(RD_PULSE), .WR_PULSE(WR_PULSE), .WR_SETUP(WR_SETUP)) dut (
    .clk(clk), .rstN(rstN),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .usbDataIn(usbDataIn), .usbDataOut(usbDataOut), .usbDataOe(usbDataOe),
    .usbRdN(usbRdN), .usbWr(usbWr), .usbTxeN(usbTxeN), .usbRxfN(usbRxfN)
  );

  int nChecks = 0;
  int nFails  = 0;

  function automatic logic [7:0] txByte(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] rxByte(input int i);
    return 8'((i * 91 + 17) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int cycle = 0;
    int txIdx = 0, accCnt = 0, wrIdx = 0, rdIdx = 0, consIdx = 0;
    int txBusy = 5, rxBusy = 5;
    int wrHigh = 0, rdLow = 0, setupCnt = 0, wrInStall = 0;
    bit txEpUsed = 0, rxEpUsed = 0, wrPrev = 0, rdWasLow = 0, firstSeen = 0;
    bit rxHeld = 0;
    logic [7:0] rxHeldData = '0;
    logic nTxeN, nRxfN, nRxReady, nTxValid;
    logic [7:0] nDin;
    bit hs;

    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(usbRdN === 1'b1, "R1 usbRdN", int'(usbRdN), 1);
    check(usbWr === 1'b0, "R1 usbWr", int'(usbWr), 0);
    check(usbDataOe === 1'b0, "R1 usbDataOe", int'(usbDataOe), 0);
    check(rxValid === 1'b0, "R1 rxValid", int'(rxValid), 0);
    txValid = 1'b1;
    txData  = txByte(0);
    @(negedge clk);
    check(txReady === 1'b0, "R1 txReady", int'(txReady), 0);
    @(posedge clk); #1;
    rstN    = 1'b1;
    rxReady = 1'b1;

    while (!(wrIdx == NTX && consIdx == NRX) && cycle < WATCHDOG) begin
      @(negedge clk);
      cycle++;
      nTxeN = usbTxeN; nRxfN = usbRxfN; nDin = usbDataIn;
      hs = txValid && txReady;

      // R9: bus released during and right after a read
      if (!usbRdN && usbDataOe) check(0, "R9 oe during read", 1, 0);
      if (rdWasLow && usbDataOe) check(0, "R9 oe after read", 1, 0);
      // R10: ready only with valid
      if (txReady && !txValid) check(0, "R10 ready w/o valid", 1, 0);
      if (hs) accCnt++;
      // R7: first event after both flags drop must be a read
      if (!firstSeen && (txReady || !usbRdN)) begin
        firstSeen = 1;
        check(!usbRdN, "R7 read first", int'(usbRdN), 0);
      end

      // transmit side of the device model
      if (usbWr && !wrPrev) begin
        check(usbTxeN == 1'b0 && !txEpUsed, "R3 write allowed", int'(usbTxeN), 0);
        txEpUsed = 1;
        check(setupCnt >= WR_SETUP, "R2 setup", setupCnt, WR_SETUP);
        check(usbDataOut == txByte(wrIdx), "R2 data", int'(usbDataOut), int'(txByte(wrIdx)));
        check(accCnt == wrIdx + 1, "R10 accept count", accCnt, wrIdx + 1);
        if (cycle >= STALL_LO && cycle < STALL_HI && rxValid) wrInStall++;
        wrHigh = 1;
      end else if (usbWr) begin
        wrHigh++;
        if (usbDataOut != txByte(wrIdx))
          check(0, "R2 data held", int'(usbDataOut), int'(txByte(wrIdx)));
      end else if (wrPrev) begin
        check(wrHigh == WR_PULSE, "R2 pulse width", wrHigh, WR_PULSE);
        check(usbDataOe == 1'b1, "R2 hold drive", int'(usbDataOe), 1);
        wrIdx++;
        nTxeN = 1'b1;
        txBusy = 3 + int'($urandom % 6) + ((($urandom % 8) == 0) ? 30 : 0);
      end
      if (usbDataOe && !usbWr) setupCnt++;
      else if (!usbDataOe) setupCnt = 0;
      wrPrev = usbWr;
      if (usbTxeN && txBusy > 0) begin
        txBusy--;
        if (txBusy == 0) begin nTxeN = 1'b0; txEpUsed = 0; end
      end

      // receive side of the device model
      if (!usbRdN && !rdWasLow) begin
        check(usbRxfN == 1'b0 && !rxEpUsed, "R5 read allowed", int'(usbRxfN), 0);
        check(!rxValid, "R6 read while full", int'(rxValid), 0);
        rxEpUsed = 1;
        rdLow = 1;
        nDin = rxByte(rdIdx);
      end else if (!usbRdN) begin
        rdLow++;
      end else if (rdWasLow) begin
        check(rdLow == RD_PULSE, "R4 pulse width", rdLow, RD_PULSE);
        rdIdx++;
        nRxfN = 1'b1;
        rxBusy = 3 + int'($urandom % 6);
        nDin = 8'($urandom);
      end
      rdWasLow = !usbRdN;
      if (usbRxfN && rxBusy > 0) begin
        rxBusy--;
        if (rxBusy == 0 && rdIdx < NRX) begin nRxfN = 1'b0; rxEpUsed = 0; end
        else if (rxBusy == 0) rxBusy = 1;
      end

      // user receive consumer
      if (rxHeld) begin
        check(rxValid && rxData == rxHeldData, "R6 hold", int'(rxData), int'(rxHeldData));
      end
      if (rxValid && rxReady) begin
        check(rxData == rxByte(consIdx), "R4 data", int'(rxData), int'(rxByte(consIdx)));
        consIdx++;
      end
      rxHeld = rxValid && !rxReady;
      rxHeldData = rxData;
      if (cycle == STALL_HI)
        check(wrInStall > 0, "R8 write while rx full", wrInStall, 1);
      nRxReady = (cycle + 1 >= STALL_LO && cycle + 1 < STALL_HI) ? 1'b0
               : (($urandom % 10) < 6);

      // user transmit producer
      if (hs) txIdx++;
      if (txIdx >= NTX)          nTxValid = 1'b0;
      else if (txValid && !hs)   nTxValid = 1'b1;
      else                       nTxValid = (($urandom % 10) < 7);

      @(posedge clk); #1;
      usbTxeN = nTxeN; usbRxfN = nRxfN; usbDataIn = nDin;
      rxReady = nRxReady; txValid = nTxValid;
      txData = txByte(txIdx);
    end

    if (cycle >= WATCHDOG) check(0, "watchdog", cycle, WATCHDOG);
    check(wrIdx == NTX, "R2 all bytes written", wrIdx, NTX);
    check(consIdx == NRX, "R4 all bytes read", consIdx, NRX);
    check(accCnt == wrIdx, "R10 accepted equals written", accCnt, wrIdx);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule